// File: doc/BRIEF.md
# Pipeline Stall and Bubble Controller

This block decides, every clock, whether an in-order five-stage pipeline (fetch, decode, execute, memory, write-back) must hold its front end, turn a decoded instruction into a no-op, or discard a fetched instruction. It looks at the decode, execute and memory pipeline registers: valid flags, source and destination register indices, load/store flags and a branch flag. It drives four control lines: hold the program counter, hold the fetch/decode register, squash the fetch/decode register, and insert a bubble into the decode/execute register. The datapath, the register file and operand forwarding are outside the block.

Three hazards are handled. A load-use hazard exists when the instruction in decode reads a register that the load now in execute is going to write. The block then holds decode and fetch for one cycle and sends a no-op down into execute. A structural hazard exists because instructions and data share a single-port memory. A load or store in the memory stage takes that port, so fetch is skipped for that cycle and a no-op is placed into fetch/decode. A control hazard exists because branch targets are only known in the memory stage. A branch reaching decode therefore freezes fetch for `FREEZE_LEN` cycles (3 by default).

Only read-after-write ordering is checked, because all register writes happen in write-back and in program order. Register index 0 is hardwired to zero and never creates a dependency. The branch freeze is a two-state machine. `HZ_RUN` is the normal state. In `HZ_RUN`, a valid branch in decode starts the freeze in that same cycle and moves the machine to `HZ_FREEZE` (transition *branch seen*). `HZ_FREEZE` counts down the remaining freeze cycles. When the count is exhausted it returns to `HZ_RUN` (transition *freeze done*). Otherwise it stays in `HZ_FREEZE` (transition *count down*). Asynchronous reset forces `HZ_RUN`.

Top module: `hazard_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it with idle inputs, all four outputs are 0 and the machine is in `HZ_RUN`. A reset during a freeze ends the freeze.
- R2: Load-use hazard. The condition is: decode valid, execute valid, execute is a load, a used decode source index equals the execute destination index, and that index is non-zero. When it holds and no freeze is active, the outputs in that same cycle are pc_hold=1, ifid_hold=1, idex_bubble=1 and ifid_squash=0.
- R3: No load-use stall is raised when the matching index is 0, when the matching source is flagged unused, when execute is invalid, or when the execute instruction is not a load.
- R4: Structural hazard. With a valid load or store in the memory stage and no freeze or load-use hazard, the outputs are pc_hold=1 and ifid_squash=1, with ifid_hold=0 and idex_bubble=0.
- R5: A valid branch in decode while in `HZ_RUN` gives pc_hold=1, ifid_squash=1, ifid_hold=0 and idex_bubble=0. These values hold in that cycle and in the following FREEZE_LEN-1 cycles (3 cycles in total by default). After that the outputs again follow the other conditions.
- R6: A branch flag seen while already in `HZ_FREEZE` neither extends nor restarts the freeze.
- R7: Priority is freeze first, then load-use, then structural. While a freeze is active, a load-use condition produces no ifid_hold and no idex_bubble. A load-use condition overrides a structural one, so ifid_squash=0.
- R8: With no hazard condition and no freeze active, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_src_idx | input | NUM_SRC x IDX_W | Source register indices of the decode instruction |
| id_src_used | input | NUM_SRC | Per-source flag: this source is actually read |
| id_branch | input | 1 | Decode instruction is a branch |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_load | input | 1 | Execute instruction is a load |
| ex_dst_idx | input | IDX_W | Destination register index of the execute instruction |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_load | input | 1 | Memory instruction is a load |
| mem_store | input | 1 | Memory instruction is a store |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_squash | output | 1 | Load a no-op into the fetch/decode register |
| idex_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The assertions assume the stage flags come from real pipeline registers. In particular, the branch flag in decode is sampled only when decode is valid. They also assume FREEZE_LEN is at least 2, so that every branch leads through `HZ_FREEZE`. The stimulus drives only those legal combinations. It uses short directed sequences for each hazard and each pair of competing hazards. It then runs a long pseudo-random phase in which register indices are drawn from a small range, so matches, index 0 and overlapping branch, load and store conditions all occur often.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic {
        HZ_RUN    = 1'b0,
        HZ_FREEZE = 1'b1
    } hz_state_e;

    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic ifid_squash;
        logic idex_bubble;
    } hz_ctrl_t;

endpackage

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
    parameter int IDX_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                            id_valid,
    input  logic [NUM_SRC-1:0][IDX_W-1:0]   id_src_idx,
    input  logic [NUM_SRC-1:0]              id_src_used,
    input  logic                            ex_valid,
    input  logic                            ex_load,
    input  logic [IDX_W-1:0]                ex_dst_idx,
    output logic                            hit
);
    logic [NUM_SRC-1:0] src_match;
    logic               dst_live;

    // the zero register never carries a dependency
    assign dst_live = ex_valid && ex_load && (ex_dst_idx != '0);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_match[s] = id_src_used[s] && (id_src_idx[s] == ex_dst_idx);
    end

    assign hit = id_valid && dst_live && (|src_match);
endmodule

// File: rtl/hzd_branch_fsm.sv
module hzd_branch_fsm
    import hzd_pkg::*;
#(
    parameter int FREEZE_LEN = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      branch_in_id,
    output logic      freeze,
    output hz_state_e state_o
);
    localparam int CNT_W = (FREEZE_LEN > 2) ? $clog2(FREEZE_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FREEZE_LEN - 2);

    hz_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             trigger;

    assign trigger = (state_q == HZ_RUN) && branch_in_id;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HZ_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HZ_RUN: begin
                if (trigger) begin            // branch seen
                    state_d = HZ_FREEZE;
                    cnt_d   = CNT_LOAD;
                end
            end
            HZ_FREEZE: begin
                if (cnt_q == '0) begin        // freeze done
                    state_d = HZ_RUN;
                end else begin                // count down
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = HZ_RUN;
        endcase
    end

    // outputs
    always_comb begin
        freeze  = trigger || (state_q == HZ_FREEZE);
        state_o = state_q;
    end
endmodule

// File: rtl/hzd_select.sv
module hzd_select
    import hzd_pkg::*;
(
    input  logic     freeze,
    input  logic     loaduse,
    input  logic     structural,
    output hz_ctrl_t ctrl
);
    always_comb begin
        ctrl = '0;
        if (freeze) begin
            ctrl.pc_hold     = 1'b1;
            ctrl.ifid_squash = 1'b1;
        end else if (loaduse) begin
            ctrl.pc_hold     = 1'b1;
            ctrl.ifid_hold   = 1'b1;
            ctrl.idex_bubble = 1'b1;
        end else if (structural) begin
            ctrl.pc_hold     = 1'b1;
            ctrl.ifid_squash = 1'b1;
        end
    end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hzd_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter int NUM_SRC    = 2,
    parameter int FREEZE_LEN = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          id_valid,
    input  logic [NUM_SRC-1:0][IDX_W-1:0] id_src_idx,
    input  logic [NUM_SRC-1:0]            id_src_used,
    input  logic                          id_branch,
    input  logic                          ex_valid,
    input  logic                          ex_load,
    input  logic [IDX_W-1:0]              ex_dst_idx,
    input  logic                          mem_valid,
    input  logic                          mem_load,
    input  logic                          mem_store,
    output logic                          pc_hold,
    output logic                          ifid_hold,
    output logic                          ifid_squash,
    output logic                          idex_bubble
);
    logic      lu_hit;
    logic      port_busy;
    logic      freeze;
    hz_state_e fsm_state;
    hz_ctrl_t  ctrl;

    hzd_loaduse #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC)) u_loaduse (
        .id_valid    (id_valid),
        .id_src_idx  (id_src_idx),
        .id_src_used (id_src_used),
        .ex_valid    (ex_valid),
        .ex_load     (ex_load),
        .ex_dst_idx  (ex_dst_idx),
        .hit         (lu_hit)
    );

    hzd_branch_fsm #(.FREEZE_LEN(FREEZE_LEN)) u_branch (
        .clk          (clk),
        .rst_n        (rst_n),
        .branch_in_id (id_valid && id_branch),
        .freeze       (freeze),
        .state_o      (fsm_state)
    );

    // the shared memory port is taken by any data access in MEM
    assign port_busy = mem_valid && (mem_load || mem_store);

    hzd_select u_select (
        .freeze     (freeze),
        .loaduse    (lu_hit),
        .structural (port_busy),
        .ctrl       (ctrl)
    );

    assign pc_hold     = ctrl.pc_hold;
    assign ifid_hold   = ctrl.ifid_hold;
    assign ifid_squash = ctrl.ifid_squash;
    assign idex_bubble = ctrl.idex_bubble;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk
    import hzd_pkg::*;
#(
    parameter int IDX_W      = 5,
    parameter int FREEZE_LEN = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_valid,
    input logic             id_branch,
    input logic             mem_valid,
    input logic             mem_load,
    input logic             mem_store,
    input logic [IDX_W-1:0] ex_dst_idx,
    input logic             pc_hold,
    input logic             ifid_hold,
    input logic             ifid_squash,
    input logic             idex_bubble,
    input hz_state_e        fsm_state
);
    int unsigned frz_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frz_run <= 0;
        else if (fsm_state == HZ_FREEZE) frz_run <= frz_run + 1;
        else frz_run <= 0;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (fsm_state == HZ_RUN) || rst_n);

    assert_bubble_with_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        idex_bubble |-> (ifid_hold && pc_hold && !ifid_squash));

    assert_zero_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst_idx == '0) |-> !idex_bubble);

    assert_port_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && (mem_load || mem_store)) |-> pc_hold);

    assert_freeze_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == HZ_RUN && id_valid && id_branch) |=> (fsm_state == HZ_FREEZE));

    assert_freeze_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == HZ_FREEZE) |-> (frz_run <= FREEZE_LEN - 2));

    assert_freeze_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == HZ_FREEZE) |-> (pc_hold && ifid_squash && !ifid_hold && !idex_bubble));

    assert_hold_squash_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ifid_hold && ifid_squash));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == HZ_RUN && !id_valid && !mem_valid) |-> !pc_hold);
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.IDX_W(IDX_W), .FREEZE_LEN(FREEZE_LEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_valid    (id_valid),
    .id_branch   (id_branch),
    .mem_valid   (mem_valid),
    .mem_load    (mem_load),
    .mem_store   (mem_store),
    .ex_dst_idx  (ex_dst_idx),
    .pc_hold     (pc_hold),
    .ifid_hold   (ifid_hold),
    .ifid_squash (ifid_squash),
    .idex_bubble (idex_bubble),
    .fsm_state   (fsm_state)
);

// File: tb/tb_hazard_ctrl.sv
module tb_hazard_ctrl;
    localparam int IDX_W      = 5;
    localparam int NUM_SRC    = 2;
    localparam int FREEZE_LEN = 3;

    logic                          clk = 1'b0;
    logic                          rst_n = 1'b0;
    logic                          id_valid = 1'b0;
    logic [NUM_SRC-1:0][IDX_W-1:0] id_src_idx = '0;
    logic [NUM_SRC-1:0]            id_src_used = '0;
    logic                          id_branch = 1'b0;
    logic                          ex_valid = 1'b0;
    logic                          ex_load = 1'b0;
    logic [IDX_W-1:0]              ex_dst_idx = '0;
    logic                          mem_valid = 1'b0;
    logic                          mem_load = 1'b0;
    logic                          mem_store = 1'b0;
    logic pc_hold, ifid_hold, ifid_squash, idex_bubble;

    int checks = 0;
    int errors = 0;
    int frz_left = 0;   // model: freeze cycles still owed after this one
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hazard_ctrl #(.IDX_W(IDX_W), .NUM_SRC(NUM_SRC), .FREEZE_LEN(FREEZE_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_src_idx(id_src_idx),
        .id_src_used(id_src_used), .id_branch(id_branch), .ex_valid(ex_valid),
        .ex_load(ex_load), .ex_dst_idx(ex_dst_idx), .mem_valid(mem_valid),
        .mem_load(mem_load), .mem_store(mem_store), .pc_hold(pc_hold),
        .ifid_hold(ifid_hold), .ifid_squash(ifid_squash), .idex_bubble(idex_bubble)
    );

    function automatic logic [3:0] expected();
        bit fz, lu, st;
        fz = (frz_left > 0) || (id_valid && id_branch);
        lu = id_valid && ex_valid && ex_load && (ex_dst_idx != 0) &&
             ((id_src_used[0] && id_src_idx[0] == ex_dst_idx) ||
              (id_src_used[1] && id_src_idx[1] == ex_dst_idx));
        st = mem_valid && (mem_load || mem_store);
        if (!rst_n) return 4'b0000;
        if (fz) return 4'b1010;   // {pc_hold, ifid_hold, ifid_squash, idex_bubble}
        if (lu) return 4'b1101;
        if (st) return 4'b1010;
        return 4'b0000;
    endfunction

    // compare mid-cycle, then advance the model across the edge
    task automatic step(string tag);
        logic [3:0] exp_v, act_v;
        #1;
        exp_v = expected();
        act_v = {pc_hold, ifid_hold, ifid_squash, idex_bubble};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: outputs %b expected %b (t=%0t)", tag, act_v, exp_v, $time);
        end
        @(posedge clk);
        if (!rst_n) frz_left = 0;
        else if (frz_left > 0) frz_left--;
        else if (id_valid && id_branch) frz_left = FREEZE_LEN - 1;
        @(negedge clk);
    endtask

    task automatic idle();
        id_valid = 0; id_src_idx = '0; id_src_used = '0; id_branch = 0;
        ex_valid = 0; ex_load = 0; ex_dst_idx = '0;
        mem_valid = 0; mem_load = 0; mem_store = 0;
    endtask

    task automatic loaduse(input int s0, input int s1, input logic [1:0] used, input int dst);
        id_valid = 1; id_src_idx[0] = IDX_W'(s0); id_src_idx[1] = IDX_W'(s1);
        id_src_used = used; ex_valid = 1; ex_load = 1; ex_dst_idx = IDX_W'(dst);
    endtask

    initial begin
        @(negedge clk);
        idle();
        step("R1");
        step("R1");
        rst_n = 1'b1;
        step("R1");
        step("R8");
        id_valid = 1; id_src_used = 2'b11; id_src_idx[0] = 5'd3; id_src_idx[1] = 5'd4;
        ex_valid = 1; ex_dst_idx = 5'd9; step("R8");
        // R2: both source positions
        idle(); loaduse(7, 2, 2'b11, 7); step("R2");
        idle(); loaduse(1, 12, 2'b11, 12); step("R2");
        idle(); step("R2");
        // R3: every disqualifier
        loaduse(0, 0, 2'b11, 0); step("R3");
        loaduse(6, 6, 2'b00, 6); step("R3");
        loaduse(6, 3, 2'b10, 6); step("R3");
        loaduse(6, 3, 2'b01, 6); ex_valid = 0; step("R3");
        loaduse(6, 3, 2'b01, 6); ex_load = 0; step("R3");
        loaduse(6, 3, 2'b01, 6); id_valid = 0; step("R3");
        // R4: load and store in MEM
        idle(); mem_valid = 1; mem_load = 1; step("R4");
        mem_load = 0; mem_store = 1; step("R4");
        mem_valid = 0; step("R4");
        // R5: branch freeze, then release
        idle(); id_valid = 1; id_branch = 1; step("R5");
        idle(); step("R5"); step("R5"); step("R5"); step("R5");
        // R6: branch flag during freeze does not extend it
        id_valid = 1; id_branch = 1; step("R6");
        step("R6"); step("R6");
        idle(); step("R6");
        // R7: priorities
        loaduse(5, 0, 2'b01, 5); id_branch = 1; mem_valid = 1; mem_load = 1; step("R7");
        id_branch = 0; step("R7"); step("R7");
        step("R7");
        idle(); loaduse(5, 0, 2'b01, 5); mem_valid = 1; mem_store = 1; step("R7");
        // R1: reset in the middle of a freeze
        idle(); id_valid = 1; id_branch = 1; step("R1");
        idle(); rst_n = 0; step("R1");
        rst_n = 1; step("R1"); step("R1");
        // pseudo-random mix against the model
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                id_valid = lfsr[0]; id_branch = lfsr[1] & lfsr[2] & lfsr[3];
                id_src_idx[0] = IDX_W'(lfsr[5:4]); id_src_idx[1] = IDX_W'(lfsr[7:6]);
                id_src_used = lfsr[9:8]; ex_valid = lfsr[10]; ex_load = lfsr[11];
                ex_dst_idx = IDX_W'(lfsr[13:12]); mem_valid = lfsr[14];
                mem_load = lfsr[15]; mem_store = lfsr[2] & ~lfsr[15];
                step("R7");
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog: run still active after %0d cycles, expected end", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule